// File: doc/BRIEF.md
# Timer Interrupt Vector Arbiter

This block decides which interrupt a timer raises and on which line. The timer has a channel 0, between one and six further capture/compare channels, and a counter overflow flag. Each source comes with a pending flag and an enable bit. Channel 0 has its own request line, and that line always wins. The other channels and the overflow flag share a second line. A read-only vector value identifies the most urgent shared source. Reading the vector, or acknowledging the channel-0 line, produces a one-cycle clear strobe back to the source that was served.

The block holds no flags of its own. The flags live in the channel logic, which drops a flag in the clock edge that follows its clear strobe. Requests, the vector and the strobes are combinational functions of the present flags, enables and strobes. This means two back-to-back reads of the vector never report the same source twice.

The channel count `NUM_CH` counts channel 0 and ranges from 2 to 7.

Top module: `tmr_irq_vector`

## Requirements
- R1: A source counts as pending only when its flag and its enable bit are both 1. A source with only one of the two set raises no request, and a vector read does not report it.
- R2: `irq0_o` is high exactly when channel 0 is pending. `ack0_i` pulses `chan_clr_o[0]` in the same cycle only while `irq0_o` is high. Otherwise the acknowledge clears nothing.
- R3: `irq1_o` is high when at least one shared source is pending and channel 0 is not pending. While channel 0 is pending, the shared line stays low.
- R4: The vector value for pending channel n (n = 1 to NUM_CH-1) is 2·n. The vector value for the overflow flag is 10 (0x0A) when NUM_CH ≤ 5, and 2·NUM_CH otherwise.
- R5: Among the pending shared sources, the lowest channel index is reported. The overflow flag is reported only when no shared channel is pending.
- R6: When `vec_rd_i` is high, the block pulses the clear strobe (`chan_clr_o[n]` or `ovf_clr_o`) of exactly the reported source, in the same cycle. No other strobe pulses. A vector read never pulses `chan_clr_o[0]`.
- R7: With no shared source pending, the vector reads 0. A read in that state pulses no clear strobe.
- R8: While `rst` is high, both request lines, all clear strobes and the vector are 0.
- R9: The vector reports the pending shared source even while channel 0 is pending and the shared line is held low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset; forces all outputs to 0 |
| chan_flag_i | input | NUM_CH | Pending flag of each channel, bit n for channel n |
| chan_ien_i | input | NUM_CH | Interrupt enable of each channel |
| ovf_flag_i | input | 1 | Counter overflow flag |
| ovf_ien_i | input | 1 | Overflow interrupt enable |
| ack0_i | input | 1 | Acknowledge of the channel-0 request line |
| vec_rd_i | input | 1 | Vector read strobe |
| irq0_o | output | 1 | Channel-0 request line |
| irq1_o | output | 1 | Shared request line |
| chan_clr_o | output | NUM_CH | Per-channel flag-clear strobe |
| ovf_clr_o | output | 1 | Overflow flag-clear strobe |
| vec_o | output | VEC_W | Vector read data |

## Verification
The bench holds its own model of the flags. It drops each flag one edge after its clear strobe and compares every output in every cycle against values it computes from the requirements.

The block has no internal state. A wrong priority, wrong code or wrong mask therefore appears at the ports in the same cycle as the input pattern that exposes it. A stray or missing clear strobe corrupts the bench's flag model, so from the next cycle onward it also shows up as a diverging vector and diverging request lines.

// File: rtl/tiv_pkg.sv
package tiv_pkg;

    localparam int MIN_CH = 2;
    localparam int MAX_CH = 7;

    // Overflow code: 0x0A while it cannot collide with a channel code.
    function automatic int ovf_code(input int num_ch);
        return (num_ch <= 5) ? 10 : 2 * num_ch;
    endfunction

    // Shared slot s: s < num_ch-1 is channel s+1, the last slot is overflow.
    function automatic int slot_code(input int slot, input int num_ch);
        return (slot < num_ch - 1) ? 2 * (slot + 1) : ovf_code(num_ch);
    endfunction

    typedef struct packed {
        logic ch0_pend;
        logic sh_any;
    } line_state_t;

endpackage

// File: rtl/tiv_qualify.sv
module tiv_qualify #(
    parameter int NUM_CH = 5
) (
    input  logic [NUM_CH-1:0] flag_i,
    input  logic [NUM_CH-1:0] ien_i,
    input  logic              ovf_flag_i,
    input  logic              ovf_ien_i,
    output logic              ch0_pend_o,
    output logic [NUM_CH-1:0] sh_pend_o
);
    localparam int NSH = NUM_CH;

    assign ch0_pend_o = flag_i[0] & ien_i[0];

    for (genvar s = 0; s < NSH - 1; s++) begin : g_chan
        assign sh_pend_o[s] = flag_i[s+1] & ien_i[s+1];
    end
    assign sh_pend_o[NSH-1] = ovf_flag_i & ovf_ien_i;

endmodule

// File: rtl/tiv_prio.sv
module tiv_prio #(
    parameter int N = 5
) (
    input  logic [N-1:0] req_i,
    output logic [N-1:0] grant_o,
    output logic         any_o
);
    always_comb begin
        logic taken;
        taken   = 1'b0;
        grant_o = '0;
        for (int i = 0; i < N; i++) begin
            if (req_i[i] && !taken) begin
                grant_o[i] = 1'b1;
                taken      = 1'b1;
            end
        end
        any_o = taken;
    end

endmodule

// File: rtl/tiv_encode.sv
module tiv_encode #(
    parameter int NUM_CH = 5,
    parameter int VEC_W  = 16
) (
    input  logic [NUM_CH-1:0] grant_i,
    output logic [VEC_W-1:0]  code_o
);
    import tiv_pkg::*;

    always_comb begin
        code_o = '0;
        for (int s = 0; s < NUM_CH; s++) begin
            if (grant_i[s]) code_o = code_o | VEC_W'(slot_code(s, NUM_CH));
        end
    end

endmodule

// File: rtl/tmr_irq_vector.sv
module tmr_irq_vector #(
    parameter int NUM_CH = 5,
    parameter int VEC_W  = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NUM_CH-1:0] chan_flag_i,
    input  logic [NUM_CH-1:0] chan_ien_i,
    input  logic              ovf_flag_i,
    input  logic              ovf_ien_i,
    input  logic              ack0_i,
    input  logic              vec_rd_i,
    output logic              irq0_o,
    output logic              irq1_o,
    output logic [NUM_CH-1:0] chan_clr_o,
    output logic              ovf_clr_o,
    output logic [VEC_W-1:0]  vec_o
);
    import tiv_pkg::*;

    localparam int NSH = NUM_CH;

    logic              ch0_pend;
    logic [NSH-1:0]    sh_pend;
    logic [NSH-1:0]    sh_grant;
    logic              sh_any;
    logic [VEC_W-1:0]  code;
    line_state_t       lines;

    tiv_qualify #(.NUM_CH(NUM_CH)) u_qual (
        .flag_i     (chan_flag_i),
        .ien_i      (chan_ien_i),
        .ovf_flag_i (ovf_flag_i),
        .ovf_ien_i  (ovf_ien_i),
        .ch0_pend_o (ch0_pend),
        .sh_pend_o  (sh_pend)
    );

    tiv_prio #(.N(NSH)) u_prio (
        .req_i   (sh_pend),
        .grant_o (sh_grant),
        .any_o   (sh_any)
    );

    tiv_encode #(.NUM_CH(NUM_CH), .VEC_W(VEC_W)) u_enc (
        .grant_i (sh_grant),
        .code_o  (code)
    );

    assign lines.ch0_pend = ch0_pend & ~rst;
    assign lines.sh_any   = sh_any & ~rst;

    always_comb begin
        irq0_o        = lines.ch0_pend;
        irq1_o        = lines.sh_any & ~lines.ch0_pend;
        vec_o         = rst ? '0 : code;
        chan_clr_o    = '0;
        chan_clr_o[0] = ack0_i & lines.ch0_pend;
        ovf_clr_o     = 1'b0;
        if (vec_rd_i && !rst) begin
            chan_clr_o[NUM_CH-1:1] = sh_grant[NSH-2:0];
            ovf_clr_o              = sh_grant[NSH-1];
        end
    end

    AST_LINES_EXCL: assert property (@(posedge clk) disable iff (rst)
        !(irq0_o && irq1_o)); // R3
    AST_ACK_IDLE: assert property (@(posedge clk) disable iff (rst)
        (ack0_i && !irq0_o) |-> !chan_clr_o[0]); // R2
    AST_ONE_CLEAR: assert property (@(posedge clk) disable iff (rst)
        $onehot0({chan_clr_o[NUM_CH-1:1], ovf_clr_o})); // R6
    AST_CLR_NEEDS_READ: assert property (@(posedge clk) disable iff (rst)
        !vec_rd_i |-> ({chan_clr_o[NUM_CH-1:1], ovf_clr_o} == '0)); // R6
    AST_CLR_PENDING: assert property (@(posedge clk) disable iff (rst)
        (chan_clr_o & ~(chan_flag_i & chan_ien_i)) == '0); // R1
    AST_EMPTY_READ: assert property (@(posedge clk) disable iff (rst)
        (vec_rd_i && vec_o == '0) |-> ({chan_clr_o[NUM_CH-1:1], ovf_clr_o} == '0)); // R7
    AST_EVEN_CODE: assert property (@(posedge clk) disable iff (rst)
        vec_o[0] == 1'b0); // R4
    AST_IDLE_LINE: assert property (@(posedge clk) disable iff (rst)
        (vec_o == '0) |-> !irq1_o); // R3

endmodule

// File: tb/tmr_irq_vector_test.sv
module tmr_irq_vector_test;
    localparam int NCH   = 5;
    localparam int VW    = 16;
    localparam int OVF_C = 10;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [NCH-1:0] flag = '0, ien = '0;
    logic           oflag = 1'b0, oien = 1'b0, ack0 = 1'b0, rd = 1'b0;
    logic           irq0, irq1, oclr;
    logic [NCH-1:0] clr;
    logic [VW-1:0]  vec;

    int checks = 0, errors = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    tmr_irq_vector #(.NUM_CH(NCH), .VEC_W(VW)) uut (
        .clk(clk), .rst(rst), .chan_flag_i(flag), .chan_ien_i(ien),
        .ovf_flag_i(oflag), .ovf_ien_i(oien), .ack0_i(ack0), .vec_rd_i(rd),
        .irq0_o(irq0), .irq1_o(irq1), .chan_clr_o(clr), .ovf_clr_o(oclr), .vec_o(vec)
    );

    function automatic int exp_vec();
        for (int n = 1; n < NCH; n++) if (flag[n] && ien[n]) return 2 * n;
        if (oflag && oien) return OVF_C;
        return 0;
    endfunction

    function automatic logic [NCH:0] exp_clr();
        logic [NCH:0] c = '0;
        int v = exp_vec();
        if (ack0 && flag[0] && ien[0]) c[0] = 1'b1;
        if (rd && v == OVF_C) c[NCH] = 1'b1;
        else if (rd && v != 0) c[v/2] = 1'b1;
        return c;
    endfunction

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Sample away from the edge, then retire cleared flags at the edge.
    task automatic cycle_check();
        logic [NCH:0] c;
        int v;
        #1;
        v = exp_vec();
        c = exp_clr();
        chk("R1/R2 irq0", int'(irq0), int'(flag[0] && ien[0]));
        chk("R3 irq1", int'(irq1), int'(v != 0 && !(flag[0] && ien[0])));
        chk("R4/R5/R9 vector", int'(vec), v);
        chk("R6/R7 channel clears", int'(clr), int'(c[NCH-1:0]));
        chk("R6 overflow clear", int'(oclr), int'(c[NCH]));
        @(posedge clk);
        #1;
        flag  = flag & ~c[NCH-1:0];
        oflag = oflag & ~c[NCH];
        ack0  = 1'b0;
        rd    = 1'b0;
    endtask

    initial begin
        #(200000 * 10);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        int seed = 32'h5eed;
        void'($urandom(seed));
        // R8: reset blanks every output even with everything pending
        flag = '1; ien = '1; oflag = 1'b1; oien = 1'b1; ack0 = 1'b1; rd = 1'b1;
        repeat (2) @(posedge clk);
        #1;
        chk("R8 reset outputs", int'({irq0, irq1, clr, oclr, vec}), 0);
        ack0 = 1'b0; rd = 1'b0;
        @(posedge clk); #1;
        rst = 1'b0;

        // R9 + R3: channel 0 holds the shared line low, vector still shows 2
        cycle_check();
        // R2: acknowledge clears channel 0, shared line follows
        ack0 = 1'b1; cycle_check();
        // R5/R4/R6: drain in order 2,4,6,8, then overflow 10
        for (int k = 0; k < NCH; k++) begin rd = 1'b1; cycle_check(); end
        // R7: nothing left, read clears nothing
        rd = 1'b1; cycle_check();
        chk("R7 empty vector", int'(vec), 0);
        // R1: flags without enables stay silent; ack with line low does nothing
        flag = '1; oflag = 1'b1; ien = '0; oien = 1'b0;
        ack0 = 1'b1; rd = 1'b1; cycle_check();
        // R1: enable without flag
        flag = '0; oflag = 1'b0; ien = '1; oien = 1'b1; rd = 1'b1; cycle_check();
        // overflow alone
        oflag = 1'b1; cycle_check();
        chk("R4 overflow code", int'(vec), OVF_C);
        rd = 1'b1; cycle_check();

        // Constrained random traffic
        for (int i = 0; i < 3000; i++) begin
            flag  = flag | NCH'($urandom & $urandom);
            oflag = oflag | (($urandom % 6) == 0);
            ien   = NCH'($urandom | $urandom);
            oien  = ($urandom % 4) != 0;
            ack0  = ($urandom % 3) == 0;
            rd    = ($urandom % 3) == 0;
            cycle_check();
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule